// File: doc/BRIEF.md
# Latency Feedback Priority Generator

This block sits on the request side of a bus master port and sets the 4-bit priority value carried with each write-address and read-address request. For each of the two address channels it times one transaction at a time, counting the cycles from the address handshake to the completion. When the transaction completes, the block adds the difference between the measured latency and a programmed target latency to a 16-bit integrator. It then converts the integrator value into a priority. The gain of that conversion is a power of two chosen by a 3-bit code. The result is clamped between a programmed floor and ceiling.

While regulation is active on a channel, the generated priority replaces whatever priority arrives from upstream on that channel. While regulation is not active, the incoming value passes through unchanged. A channel is active when its enable bit is set and its target latency is not zero. If latency stays above target, the integrator keeps rising and so does the priority. If latency falls below target, the integrator drains back toward zero. A larger gain code makes the priority react more slowly. The write and read channels are fully independent copies.

Top module: `lat_qos_gen`

## Requirements
- R1: After reset, both channels are inactive and each priority output equals its incoming priority input.
- R2: While a channel is active, its priority output is the generated value rather than the incoming value. With the integrator at zero, that value equals the programmed floor.
- R3: A target latency of zero makes the channel inactive even when its enable bit is set, so the incoming priority passes through.
- R4: The measured latency is the number of clock cycles from the cycle in which the handshake is sampled to the cycle in which the completion is sampled. On each completion the integrator changes by measured minus target.
- R5: The integrator never drops below zero. A completion with latency below target drains the integrator but stops at zero.
- R6: The integrator saturates at 65535 and does not wrap.
- R7: The generated priority equals floor + (integrator >> (5 + code)), where code is the 3-bit gain code, 0..7.
- R8: The generated priority never exceeds the programmed ceiling. A larger sum is clamped to the ceiling.
- R9: The latency counter saturates at 4095 cycles. A longer transaction is measured as 4095.
- R10: Only one transaction per channel is timed. A handshake that arrives while a transaction is being timed does not restart the timer, and a completion that arrives while no transaction is being timed leaves the integrator unchanged.
- R11: The write and read channels use separate settings and separate state. Activity on one channel does not change the other channel's output.
- R12: Making a channel inactive clears its integrator and abandons any timing in progress. When the channel is re-enabled, it starts again at the floor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write-channel regulation enable |
| wr_target | input | 12 | Write-channel target latency in cycles; zero disables |
| wr_gain | input | 3 | Write-channel gain code (shift 5 + code) |
| wr_qmin | input | 4 | Write-channel priority floor |
| wr_qmax | input | 4 | Write-channel priority ceiling |
| wr_addr_hs | input | 1 | Write-address handshake accepted this cycle |
| wr_cmpl | input | 1 | Write transaction completion this cycle |
| wr_qos_in | input | 4 | Incoming write priority |
| wr_qos | output | 4 | Outgoing write priority |
| rd_en | input | 1 | Read-channel regulation enable |
| rd_target | input | 12 | Read-channel target latency in cycles; zero disables |
| rd_gain | input | 3 | Read-channel gain code |
| rd_qmin | input | 4 | Read-channel priority floor |
| rd_qmax | input | 4 | Read-channel priority ceiling |
| rd_addr_hs | input | 1 | Read-address handshake accepted this cycle |
| rd_cmpl | input | 1 | Read transaction completion this cycle |
| rd_qos_in | input | 4 | Incoming read priority |
| rd_qos | output | 4 | Outgoing read priority |

## Verification
The bench targets the integrator limits. It drives seventeen maximal-latency transactions, which separates a saturating accumulator from one that wraps back to a small value, and it drives a short latency that would push a missing zero floor into a huge unsigned value. A 5000-cycle transaction exposes a counter that wraps instead of holding at 4095, because the wrapped count yields a visibly different priority. Duplicate handshakes in mid-flight, and a completion with nothing in flight, expose timers that restart or that add a stale count. The bench also checks clamping to the ceiling, the distinct shift for each gain code, and the clearing of the integrator when a channel is disabled.

// File: rtl/lat_qos_pkg.sv
// Shared constants and channel indices for the latency feedback priority generator.
// Assumes two address channels (write, read) with identical regulator structure.
package lat_qos_pkg;
    localparam int LQ_TGT_W     = 12;  // latency / target width in cycles
    localparam int LQ_ACC_W     = 16;  // integrator width
    localparam int LQ_QOS_W     = 4;   // priority width
    localparam int LQ_GAIN_W    = 3;   // gain code width
    localparam int LQ_GAIN_BASE = 5;   // shift applied at gain code 0
    localparam int LQ_NCH       = 2;   // number of address channels

    typedef enum int {
        CH_WR = 0,
        CH_RD = 1
    } lq_chan_e;
endpackage

// File: rtl/lat_timer.sv
// Times one transaction: starts on a handshake while idle, stops on a completion.
// Assumes completions return in order so the first completion closes the timed one.
// The count holds at its all-ones value; it is cleared while the channel is inactive.
module lat_timer #(
    parameter int TGT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             hs_i,
    input  logic             cmpl_i,
    output logic             sample_o,
    output logic [TGT_W-1:0] meas_o
);
    logic             busy_q;
    logic [TGT_W-1:0] cnt_q;

    // A completion counts only while a transaction is being timed.
    assign sample_o = active_i & busy_q & cmpl_i;
    assign meas_o   = cnt_q;

    // Track the in-flight transaction and its saturating cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cmpl_i) begin
                busy_q <= hs_i;
                if (hs_i) cnt_q <= {{(TGT_W-1){1'b0}}, 1'b1};
            end else if (cnt_q != {TGT_W{1'b1}}) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (hs_i) begin
            busy_q <= 1'b1;
            cnt_q  <= {{(TGT_W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/lat_integ.sv
// Integrates (measured - target) on each sample, saturating at zero and at full scale.
// Assumes TGT_W is not wider than ACC_W. It is cleared while the channel is inactive.
module lat_integ #(
    parameter int TGT_W = 12,
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             sample_i,
    input  logic [TGT_W-1:0] meas_i,
    input  logic [TGT_W-1:0] target_i,
    output logic [ACC_W-1:0] acc_o
);
    localparam int SW = ACC_W + 2;
    localparam logic signed [SW-1:0] ACC_MAX_S = $signed({2'b00, {ACC_W{1'b1}}});

    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    acc_nxt;
    logic signed [SW-1:0] sum;

    // Form the signed updated sum and clamp it into the unsigned range.
    always_comb begin
        sum = $signed({2'b00, acc_q})
            + $signed({{(SW-TGT_W){1'b0}}, meas_i})
            - $signed({{(SW-TGT_W){1'b0}}, target_i});
        if (sum < 0)
            acc_nxt = '0;
        else if (sum > ACC_MAX_S)
            acc_nxt = {ACC_W{1'b1}};
        else
            acc_nxt = sum[ACC_W-1:0];
    end

    // Hold the integrator, update on a sample, clear when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i)
            acc_q <= '0;
        else if (sample_i)
            acc_q <= acc_nxt;
    end

    assign acc_o = acc_q;
endmodule

// File: rtl/qos_map.sv
// Maps the integrator to a priority: floor + (acc >> (GAIN_BASE + code)), capped at ceiling.
// Assumes the floor is not above the ceiling; otherwise the ceiling is produced.
module qos_map #(
    parameter int ACC_W     = 16,
    parameter int QOS_W     = 4,
    parameter int GAIN_W    = 3,
    parameter int GAIN_BASE = 5
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [GAIN_W-1:0] code_i,
    input  logic [QOS_W-1:0]  qmin_i,
    input  logic [QOS_W-1:0]  qmax_i,
    output logic [QOS_W-1:0]  prio_o
);
    logic [ACC_W-1:0] shifted;
    logic [ACC_W:0]   total;
    logic [ACC_W:0]   cap;

    // Scale the integrator, offset by the floor and clamp to the ceiling.
    always_comb begin
        shifted = acc_i >> (GAIN_BASE + int'(code_i));
        total   = {1'b0, shifted} + {{(ACC_W+1-QOS_W){1'b0}}, qmin_i};
        cap     = {{(ACC_W+1-QOS_W){1'b0}}, qmax_i};
        prio_o  = (total > cap) ? qmax_i : total[QOS_W-1:0];
    end
endmodule

// File: rtl/lat_qos_chan.sv
// One channel's regulator: timer, integrator, priority map and output override.
// Active only when enabled with a non-zero target; otherwise the input priority passes.
module lat_qos_chan #(
    parameter int TGT_W     = 12,
    parameter int ACC_W     = 16,
    parameter int QOS_W     = 4,
    parameter int GAIN_W    = 3,
    parameter int GAIN_BASE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic [GAIN_W-1:0] gain_i,
    input  logic [QOS_W-1:0]  qmin_i,
    input  logic [QOS_W-1:0]  qmax_i,
    input  logic              hs_i,
    input  logic              cmpl_i,
    input  logic [QOS_W-1:0]  qos_i,
    output logic [QOS_W-1:0]  qos_o,
    output logic              active_o,
    output logic [ACC_W-1:0]  acc_o
);
    logic             active;
    logic             sample;
    logic [TGT_W-1:0] meas;
    logic [QOS_W-1:0] prio;

    // Regulation runs only with the enable set and a meaningful target.
    assign active = en_i & (target_i != '0);

    lat_timer #(.TGT_W(TGT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .hs_i     (hs_i),
        .cmpl_i   (cmpl_i),
        .sample_o (sample),
        .meas_o   (meas)
    );

    lat_integ #(.TGT_W(TGT_W), .ACC_W(ACC_W)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .sample_i (sample),
        .meas_i   (meas),
        .target_i (target_i),
        .acc_o    (acc_o)
    );

    qos_map #(.ACC_W(ACC_W), .QOS_W(QOS_W), .GAIN_W(GAIN_W), .GAIN_BASE(GAIN_BASE)) u_map (
        .acc_i  (acc_o),
        .code_i (gain_i),
        .qmin_i (qmin_i),
        .qmax_i (qmax_i),
        .prio_o (prio)
    );

    // Override the incoming priority while regulating.
    assign qos_o    = active ? prio : qos_i;
    assign active_o = active;
endmodule

// File: rtl/lat_qos_gen.sv
// Top level: two independent latency-feedback priority regulators (write, read).
// Assumes the handshake and completion strobes are single-cycle and in this clock domain.
module lat_qos_gen
    import lat_qos_pkg::*;
#(
    parameter int TGT_W     = LQ_TGT_W,
    parameter int ACC_W     = LQ_ACC_W,
    parameter int QOS_W     = LQ_QOS_W,
    parameter int GAIN_W    = LQ_GAIN_W,
    parameter int GAIN_BASE = LQ_GAIN_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TGT_W-1:0]  wr_target,
    input  logic [GAIN_W-1:0] wr_gain,
    input  logic [QOS_W-1:0]  wr_qmin,
    input  logic [QOS_W-1:0]  wr_qmax,
    input  logic              wr_addr_hs,
    input  logic              wr_cmpl,
    input  logic [QOS_W-1:0]  wr_qos_in,
    output logic [QOS_W-1:0]  wr_qos,
    input  logic              rd_en,
    input  logic [TGT_W-1:0]  rd_target,
    input  logic [GAIN_W-1:0] rd_gain,
    input  logic [QOS_W-1:0]  rd_qmin,
    input  logic [QOS_W-1:0]  rd_qmax,
    input  logic              rd_addr_hs,
    input  logic              rd_cmpl,
    input  logic [QOS_W-1:0]  rd_qos_in,
    output logic [QOS_W-1:0]  rd_qos
);
    localparam int NCH = LQ_NCH;

    logic [NCH-1:0]             en_w, hs_w, cmpl_w, act_w;
    logic [NCH-1:0][TGT_W-1:0]  tgt_w;
    logic [NCH-1:0][GAIN_W-1:0] gain_w;
    logic [NCH-1:0][QOS_W-1:0]  qmin_w, qmax_w, qin_w, qout_w;
    logic [NCH-1:0][ACC_W-1:0]  acc_w;

    // Gather the per-channel ports into indexed arrays.
    always_comb begin
        en_w[CH_WR]   = wr_en;       en_w[CH_RD]   = rd_en;
        hs_w[CH_WR]   = wr_addr_hs;  hs_w[CH_RD]   = rd_addr_hs;
        cmpl_w[CH_WR] = wr_cmpl;     cmpl_w[CH_RD] = rd_cmpl;
        tgt_w[CH_WR]  = wr_target;   tgt_w[CH_RD]  = rd_target;
        gain_w[CH_WR] = wr_gain;     gain_w[CH_RD] = rd_gain;
        qmin_w[CH_WR] = wr_qmin;     qmin_w[CH_RD] = rd_qmin;
        qmax_w[CH_WR] = wr_qmax;     qmax_w[CH_RD] = rd_qmax;
        qin_w[CH_WR]  = wr_qos_in;   qin_w[CH_RD]  = rd_qos_in;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lat_qos_chan #(
            .TGT_W(TGT_W), .ACC_W(ACC_W), .QOS_W(QOS_W),
            .GAIN_W(GAIN_W), .GAIN_BASE(GAIN_BASE)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (en_w[c]),
            .target_i (tgt_w[c]),
            .gain_i   (gain_w[c]),
            .qmin_i   (qmin_w[c]),
            .qmax_i   (qmax_w[c]),
            .hs_i     (hs_w[c]),
            .cmpl_i   (cmpl_w[c]),
            .qos_i    (qin_w[c]),
            .qos_o    (qout_w[c]),
            .active_o (act_w[c]),
            .acc_o    (acc_w[c])
        );
    end

    assign wr_qos = qout_w[CH_WR];
    assign rd_qos = qout_w[CH_RD];
endmodule

// File: rtl/lat_qos_chk.sv
// Property checker for lat_qos_gen, attached by bind; observes per-channel state.
module lat_qos_chk #(
    parameter int NCH   = 2,
    parameter int ACC_W = 16,
    parameter int QOS_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            act,
    input logic [NCH-1:0]            cmpl,
    input logic [NCH-1:0][ACC_W-1:0] acc,
    input logic [NCH-1:0][QOS_W-1:0] qmin,
    input logic [NCH-1:0][QOS_W-1:0] qmax,
    input logic [NCH-1:0][QOS_W-1:0] qout
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R1
        reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> acc[c] == '0);
        // R12
        idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !act[c] |=> acc[c] == '0);
        // R10
        hold_no_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act[c] && !cmpl[c]) |=> $stable(acc[c]));
        // R8
        ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act[c] && qmin[c] <= qmax[c]) |-> qout[c] <= qmax[c]);
        // R2
        floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act[c] && qmin[c] <= qmax[c]) |-> qout[c] >= qmin[c]);
    end
endmodule

bind lat_qos_gen lat_qos_chk #(.NCH(NCH), .ACC_W(ACC_W), .QOS_W(QOS_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act_w),
    .cmpl  (cmpl_w),
    .acc   (acc_w),
    .qmin  (qmin_w),
    .qmax  (qmax_w),
    .qout  (qout_w)
);

// File: tb/sim_lat_qos_gen.sv
`timescale 1ns/1ps
module sim_lat_qos_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 0, rd_en = 0;
    logic [11:0] wr_target = 0, rd_target = 0;
    logic [2:0] wr_gain = 0, rd_gain = 0;
    logic [3:0] wr_qmin = 0, wr_qmax = 15, rd_qmin = 0, rd_qmax = 15;
    logic       wr_addr_hs = 0, wr_cmpl = 0, rd_addr_hs = 0, rd_cmpl = 0;
    logic [3:0] wr_qos_in = 4'd9, rd_qos_in = 4'd9;
    logic [3:0] wr_qos, rd_qos;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lat_qos_gen u0 (.*);

    typedef struct packed {
        logic [11:0] tgt;
        logic [2:0]  gain;
        logic [3:0]  qmin;
        logic [3:0]  qmax;
        logic [12:0] lat;
        logic [3:0]  exp;
    } vec_t;

    // Each vector: fresh write channel, one transaction, expected priority.
    localparam vec_t VEC [6] = '{
        '{12'd10,  3'd0, 4'd2, 4'd15, 13'd74,  4'd4},   // R7: 64>>5=2, +2
        '{12'd10,  3'd0, 4'd0, 4'd15, 13'd5,   4'd0},   // R5: below target floors at 0
        '{12'd1,   3'd1, 4'd1, 4'd15, 13'd129, 4'd3},   // R7: 128>>6=2, +1
        '{12'd100, 3'd0, 4'd3, 4'd6,  13'd400, 4'd6},   // R8: 3+9 clamped to 6
        '{12'd4,   3'd7, 4'd5, 4'd15, 13'd300, 4'd5},   // R7: 296>>12=0, +5
        '{12'd2,   3'd2, 4'd0, 4'd15, 13'd258, 4'd2}    // R4: 256>>7=2
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Handshake sampled at one edge, completion sampled lat edges later.
    task automatic txn(input int ch, input int lat);
        if (ch == 0) wr_addr_hs = 1; else rd_addr_hs = 1;
        @(negedge clk);
        wr_addr_hs = 0; rd_addr_hs = 0;
        repeat (lat - 1) @(negedge clk);
        if (ch == 0) wr_cmpl = 1; else rd_cmpl = 1;
        @(negedge clk);
        wr_cmpl = 0; rd_cmpl = 0;
    endtask

    task automatic wr_fresh(input int tgt, input int g, input int mn, input int mx);
        wr_en = 0;
        @(negedge clk);
        wr_target = 12'(tgt); wr_gain = 3'(g); wr_qmin = 4'(mn); wr_qmax = 4'(mx);
        wr_en = 1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 wr passthrough", wr_qos, 4'd9);
        check("R1 rd passthrough", rd_qos, 4'd9);

        // R2: enabled with empty integrator gives the floor, not the input
        wr_fresh(10, 0, 6, 15);
        check("R2 override to floor", wr_qos, 4'd6);

        // R3: zero target keeps passthrough even with enable and traffic
        wr_fresh(0, 0, 6, 15);
        txn(0, 200);
        check("R3 zero target passthrough", wr_qos, 4'd9);

        // Table of single-transaction vectors
        foreach (VEC[i]) begin
            wr_fresh(int'(VEC[i].tgt), int'(VEC[i].gain), int'(VEC[i].qmin), int'(VEC[i].qmax));
            txn(0, int'(VEC[i].lat));
            check($sformatf("R7 vector %0d", i), wr_qos, VEC[i].exp);
        end

        // R10: completion with nothing in flight must not add to the integrator
        wr_fresh(10, 0, 0, 15);
        txn(0, 74);
        check("R4 accumulate 64", wr_qos, 4'd2);
        wr_cmpl = 1; @(negedge clk); wr_cmpl = 0; @(negedge clk);
        check("R10 idle completion ignored", wr_qos, 4'd2);
        // R10: second handshake in flight does not restart timing
        wr_addr_hs = 1; @(negedge clk); wr_addr_hs = 0;
        repeat (18) @(negedge clk);
        wr_addr_hs = 1; @(negedge clk); wr_addr_hs = 0;
        repeat (54) @(negedge clk);
        wr_cmpl = 1; @(negedge clk); wr_cmpl = 0;
        check("R10 no restart on extra handshake", wr_qos, 4'd4);
        // R5: a short latency drains the integrator (128-8=120)
        txn(0, 2);
        check("R5 drain", wr_qos, 4'd3);

        // R11: read channel runs on its own settings; write output unaffected
        rd_target = 12'd10; rd_gain = 3'd0; rd_qmin = 4'd1; rd_qmax = 4'd15; rd_en = 1;
        @(negedge clk);
        txn(1, 74);
        check("R11 read result", rd_qos, 4'd3);
        check("R11 write unchanged", wr_qos, 4'd3);

        // R9: 5000-cycle latency measured as 4095 -> 4094>>9 = 7
        wr_fresh(1, 4, 0, 15);
        txn(0, 5000);
        check("R9 counter saturates", wr_qos, 4'd7);

        // R6: 17 long transactions of +4094 each saturate at 65535
        wr_fresh(1, 7, 0, 15);
        for (int k = 0; k < 15; k++) txn(0, 4200);
        check("R6 before limit", wr_qos, 4'd14);
        for (int k = 0; k < 2; k++) txn(0, 4200);
        check("R6 integrator saturates", wr_qos, 4'd15);

        // R12: disabling clears the integrator
        wr_fresh(1, 7, 0, 15);
        check("R12 cleared on disable", wr_qos, 4'd0);

        finish_run();
    end
endmodule